// File: doc/BRIEF.md
# Predicated Structure Load Sequencer

This block carries out one already-decoded predicated contiguous vector load. A single start pulse hands it the following:

- a start address;
- the size of the memory item and whether it is signed;
- the size of a vector element;
- how many destination registers to fill (one to four);
- the number of the first destination register;
- a predicate with one bit per vector byte.

The sequencer then steps through the vector one element at a time, starting at element zero.

For an active element it reads one memory item for each destination register. It issues these reads one after another over a valid/ready request port and receives each result over a response port. The first item read goes to the first register, the next to the register after it, and so on. In this way a memory structure is de-interleaved across consecutive registers, and the register number wraps modulo 32.

For an inactive element it issues no memory read and writes zero to every destination register. The address still moves past that element's structure, so the address steps by the same amount for every element.

Every result leaves through a single-cycle register-file write port. A write carries the register number, the element index, the element size and the element data. The data is zero-extended or sign-extended from the memory item size to the element size.

Top module: `strload_seq`

## Requirements
- R1: A load covers VEC_BYTES >> elemSize elements (size code 0=1, 1=2, 2=4, 3=8 bytes), and the writes for them appear in strictly ascending element index.
- R2: An element with index e is active exactly when predBits[e << elemSize] is 1. The predicate bits for the element's other bytes have no effect.
- R3: For an active element, regCountM1+1 reads are issued in order. Read k is at elementAddr + k·itemBytes, with memReqSize equal to itemSize, and its result is written to register firstReg + k.
- R4: For an inactive element, no memory request is issued, and one write of zero data is made for each destination register.
- R5: elementAddr starts at startAddr and grows by (regCountM1+1)·itemBytes after every element, whether the element was active or not.
- R6: The item is taken from the low itemBytes of memRspData, and the higher response bits are ignored. It is sign-extended when itemSigned is 1 and zero-extended otherwise, then cut to the element width. Bits of rfWrData above the element width are zero. itemSize must not exceed elemSize.
- R7: Destination register numbers wrap modulo 32. For example, four registers starting at register 30 are registers 30, 31, 0 and 1.
- R8: busy rises in the cycle after an accepted startPulse and stays high until the last write. done pulses for one cycle together with the last write, and busy is low in that cycle. Out of reset, busy, done, rfWrEn and memReqValid are all 0.
- R9: At most one memory request is outstanding at a time. While memReqValid is high and memReqReady is low, the request stays asserted and its address does not change.
- R10: Each write reports the register, the element index and the element size code of the load, and is accepted in the cycle rfWrEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a load when the block is idle |
| startAddr | input | ADDR_W | Address of the first structure |
| itemSize | input | 2 | Memory item size code (0=1,1=2,2=4,3=8 bytes) |
| itemSigned | input | 1 | 1 = sign-extend the item, 0 = zero-extend |
| elemSize | input | 2 | Vector element size code |
| regCountM1 | input | 2 | Number of destination registers minus one |
| firstReg | input | REG_W | First destination register |
| predBits | input | VEC_BYTES | Predicate, one bit per vector byte |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Read address |
| memReqSize | output | 2 | Read size code |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data, item in the low bytes |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrReg | output | REG_W | Destination register |
| rfWrIdx | output | IDX_W | Element index |
| rfWrSize | output | 2 | Element size code |
| rfWrData | output | 64 | Element value, right-aligned |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The final element write and the done pulse fall in the same cycle, and busy drops in that cycle too. Runs are chosen to end on an active last element with a slow memory response, and also on an inactive last element that is zero-filled without any memory traffic. A behavioural model in the bench builds the expected request and write streams from the requirements, and every output is compared on each clock. When done appears, the bench requires that the expected write stream is exactly empty and that busy is low, so an early or late completion pulse is reported.

// File: rtl/strload_pkg.sv
package strload_pkg;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic load;      // capture the operands
    logic wrMem;     // write the extended memory item
    logic wrZero;    // write zero for an inactive element
    logic nextItem;  // step to the next register of the structure
    logic nextElem;  // step to the next element
    logic finish;    // last write of the load
  } seqStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_REQ, S_WAIT, S_ZERO
  } seqState_t;

  // Extend an item of size code iSz to 64 bits, then clip it to element size code eSz
  function automatic logic [63:0] extendItem(input logic [63:0] raw,
                                             input logic [1:0] iSz,
                                             input logic sgn,
                                             input logic [1:0] eSz);
    logic [63:0] v;
    logic [63:0] m;
    case (iSz)
      2'd0:    v = {{56{sgn & raw[7]}}, raw[7:0]};
      2'd1:    v = {{48{sgn & raw[15]}}, raw[15:0]};
      2'd2:    v = {{32{sgn & raw[31]}}, raw[31:0]};
      default: v = raw;
    endcase
    case (eSz)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = '1;
    endcase
    return v & m;
  endfunction

endpackage

// File: rtl/strload_ctl.sv
module strload_ctl
  import strload_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       isActive,
  input  logic       lastItem,
  input  logic       lastElem,
  output seqStrobe_t strobe,
  output logic       memReqValid,
  output logic       busy
);

  seqState_t state, nextState;
  logic      stepping;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe      = '0;
    nextState   = state;
    memReqValid = 1'b0;
    stepping    = 1'b0;
    case (state)
      S_IDLE: if (startPulse) begin
        strobe.load = 1'b1;
        nextState   = S_EVAL;
      end
      S_EVAL: nextState = isActive ? S_REQ : S_ZERO;
      S_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = S_WAIT;
      end
      S_WAIT: if (memRspValid) begin
        strobe.wrMem = 1'b1;
        stepping     = 1'b1;
      end
      S_ZERO: begin
        strobe.wrZero = 1'b1;
        stepping      = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
    if (stepping) begin
      if (!lastItem) begin
        strobe.nextItem = 1'b1;
        nextState       = (state == S_WAIT) ? S_REQ : S_ZERO;
      end else if (!lastElem) begin
        strobe.nextElem = 1'b1;
        nextState       = S_EVAL;
      end else begin
        strobe.finish = 1'b1;
        nextState     = S_IDLE;
      end
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/strload_dp.sv
module strload_dp
  import strload_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int ADDR_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int REG_W    = $clog2(REG_COUNT),
  localparam int IDX_W    = $clog2(VEC_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [1:0]           itemSize,
  input  logic                 itemSigned,
  input  logic [1:0]           elemSize,
  input  logic [1:0]           regCountM1,
  input  logic [REG_W-1:0]     firstReg,
  input  logic [VEC_BYTES-1:0] predBits,
  input  logic [63:0]          memRspData,
  output logic                 isActive,
  output logic                 lastItem,
  output logic                 lastElem,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic [1:0]           memReqSize,
  output logic                 rfWrEn,
  output logic [REG_W-1:0]     rfWrReg,
  output logic [IDX_W-1:0]     rfWrIdx,
  output logic [1:0]           rfWrSize,
  output logic [63:0]          rfWrData,
  output logic                 done
);

  logic [ADDR_W-1:0]    elemAddr;
  logic [1:0]           itemCnt;
  logic [IDX_W-1:0]     elemIdx;
  logic [1:0]           itemSzQ, elemSzQ, nregQ;
  logic                 signQ;
  logic [REG_W-1:0]     firstRegQ;
  logic [VEC_BYTES-1:0] predQ;

  logic [IDX_W-1:0]     bytePos;
  logic [IDX_W:0]       elemTotal;
  logic [ADDR_W-1:0]    stride;

  assign bytePos    = elemIdx << elemSzQ;
  assign isActive   = predQ[bytePos];
  assign elemTotal  = (IDX_W+1)'(VEC_BYTES) >> elemSzQ;
  assign lastElem   = ({1'b0, elemIdx} == elemTotal - 1'b1);
  assign lastItem   = (itemCnt == nregQ);
  assign stride     = ADDR_W'({1'b0, nregQ} + 3'd1) << itemSzQ;
  assign memReqAddr = elemAddr + (ADDR_W'(itemCnt) << itemSzQ);
  assign memReqSize = itemSzQ;

  // Operand capture and walk state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      elemAddr  <= '0;
      itemCnt   <= '0;
      elemIdx   <= '0;
      itemSzQ   <= '0;
      elemSzQ   <= '0;
      nregQ     <= '0;
      signQ     <= 1'b0;
      firstRegQ <= '0;
      predQ     <= '0;
    end else if (strobe.load) begin
      elemAddr  <= startAddr;
      itemCnt   <= '0;
      elemIdx   <= '0;
      itemSzQ   <= itemSize;
      elemSzQ   <= elemSize;
      nregQ     <= regCountM1;
      signQ     <= itemSigned;
      firstRegQ <= firstReg;
      predQ     <= predBits;
    end else if (strobe.nextItem) begin
      itemCnt <= itemCnt + 2'd1;
    end else if (strobe.nextElem) begin
      itemCnt  <= '0;
      elemIdx  <= elemIdx + 1'b1;
      elemAddr <= elemAddr + stride;
    end
  end

  // Registered register-file write port and completion pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rfWrEn   <= 1'b0;
      rfWrReg  <= '0;
      rfWrIdx  <= '0;
      rfWrSize <= '0;
      rfWrData <= '0;
      done     <= 1'b0;
    end else begin
      rfWrEn <= strobe.wrMem | strobe.wrZero;
      done   <= strobe.finish;
      if (strobe.wrMem | strobe.wrZero) begin
        rfWrReg  <= firstRegQ + REG_W'(itemCnt);
        rfWrIdx  <= elemIdx;
        rfWrSize <= elemSzQ;
        rfWrData <= strobe.wrMem ? extendItem(memRspData, itemSzQ, signQ, elemSzQ) : '0;
      end
    end
  end

endmodule

// File: rtl/strload_seq.sv
module strload_seq
  import strload_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int ADDR_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int REG_W    = $clog2(REG_COUNT),
  localparam int IDX_W    = $clog2(VEC_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [1:0]           itemSize,
  input  logic                 itemSigned,
  input  logic [1:0]           elemSize,
  input  logic [1:0]           regCountM1,
  input  logic [REG_W-1:0]     firstReg,
  input  logic [VEC_BYTES-1:0] predBits,
  output logic                 memReqValid,
  input  logic                 memReqReady,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic [1:0]           memReqSize,
  input  logic                 memRspValid,
  input  logic [63:0]          memRspData,
  output logic                 rfWrEn,
  output logic [REG_W-1:0]     rfWrReg,
  output logic [IDX_W-1:0]     rfWrIdx,
  output logic [1:0]           rfWrSize,
  output logic [63:0]          rfWrData,
  output logic                 busy,
  output logic                 done
);

  seqStrobe_t strobe;
  logic       isActive, lastItem, lastElem;

  strload_ctl i_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .isActive(isActive), .lastItem(lastItem), .lastElem(lastElem),
    .strobe(strobe), .memReqValid(memReqValid), .busy(busy)
  );

  strload_dp #(.VEC_BYTES(VEC_BYTES), .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startAddr(startAddr), .itemSize(itemSize), .itemSigned(itemSigned),
    .elemSize(elemSize), .regCountM1(regCountM1), .firstReg(firstReg),
    .predBits(predBits), .memRspData(memRspData),
    .isActive(isActive), .lastItem(lastItem), .lastElem(lastElem),
    .memReqAddr(memReqAddr), .memReqSize(memReqSize),
    .rfWrEn(rfWrEn), .rfWrReg(rfWrReg), .rfWrIdx(rfWrIdx),
    .rfWrSize(rfWrSize), .rfWrData(rfWrData), .done(done)
  );

endmodule

// File: rtl/strload_seq_chk.sv
module strload_seq_chk #(
  parameter int VEC_BYTES = 16,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(VEC_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              busy,
  input logic              done,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              rfWrEn,
  input logic [IDX_W-1:0]  rfWrIdx,
  input logic [1:0]        rfWrSize,
  input logic [63:0]       rfWrData
);

  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN)                            outstanding <= 1'b0;
    else if (memReqValid && memReqReady)  outstanding <= 1'b1;
    else if (memRspValid)                 outstanding <= 1'b0;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R9
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !memReqValid);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !busy |=> busy);

  // R8
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> rfWrEn && !busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (int'(rfWrIdx) < (VEC_BYTES >> rfWrSize)));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn && (rfWrSize != 2'd3) |-> ((rfWrData >> (8 << rfWrSize)) == 64'd0));

endmodule

bind strload_seq strload_seq_chk #(.VEC_BYTES(VEC_BYTES), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .busy(busy), .done(done),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .memRspValid(memRspValid), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
  .rfWrSize(rfWrSize), .rfWrData(rfWrData)
);

// File: tb/test_strload_seq.sv
module test_strload_seq;
  localparam int VB = 16;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [1:0]    itemSize = '0, elemSize = '0, regCountM1 = '0;
  logic          itemSigned = 1'b0;
  logic [4:0]    firstReg = '0;
  logic [VB-1:0] predBits = '0;
  logic          memReqValid, memReqReady = 1'b0;
  logic [AW-1:0] memReqAddr;
  logic [1:0]    memReqSize;
  logic          memRspValid = 1'b0;
  logic [63:0]   memRspData = '0;
  logic          rfWrEn;
  logic [4:0]    rfWrReg;
  logic [3:0]    rfWrIdx;
  logic [1:0]    rfWrSize;
  logic [63:0]   rfWrData;
  logic          busy, done;

  strload_seq #(.VEC_BYTES(VB), .ADDR_W(AW)) i_strload_seq (.*);

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit doneSeen = 0;
  int curIsz = 0;

  // expected streams
  logic [AW-1:0] qAddr[$];
  int            qReg[$], qIdx[$], qSize[$];
  logic [63:0]   qData[$];

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return 8'((a * 37) ^ (a >> 3));
  endfunction

  function automatic logic [63:0] readItem(input logic [AW-1:0] a, input int isz);
    logic [63:0] v = '0;
    for (int b = 0; b < (1 << isz); b++) v |= 64'(memByte(a + AW'(b))) << (8 * b);
    return v;
  endfunction

  function automatic logic [63:0] refExt(input logic [63:0] v, input int isz,
                                         input bit sgn, input int esz);
    int ib = 8 << isz;
    int eb = 8 << esz;
    logic [63:0] r = v;
    if (sgn && ib < 64 && r[ib-1]) r |= ~((64'd1 << ib) - 64'd1);
    if (eb < 64) r &= (64'd1 << eb) - 64'd1;
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Memory model and per-clock comparison
  int pendCnt = -1;
  logic [AW-1:0] pendAddr;
  always @(negedge clk) begin
    cycles++;
    memRspValid <= 1'b0;
    if (pendCnt == 0) begin
      memRspValid <= 1'b1;
      memRspData  <= readItem(pendAddr, curIsz) | (~64'd0 << (8 << curIsz) & {8{8'hC3}});
      pendCnt = -1;
    end else if (pendCnt > 0) pendCnt--;
    memReqReady <= (cycles % 3 != 1);
    if (memReqValid && (cycles % 3 != 1) && pendCnt == -1) begin
      if (qAddr.size() == 0)
        check(0, "R4 unexpected memory request", 64'(memReqAddr), 64'd0);
      else begin
        check(memReqAddr == qAddr[0], "R3 R5 request address", 64'(memReqAddr), 64'(qAddr[0]));
        check(int'(memReqSize) == curIsz, "R3 request size", 64'(memReqSize), 64'(curIsz));
        void'(qAddr.pop_front());
      end
      pendAddr = memReqAddr;
      pendCnt  = cycles % 3;
    end
    if (rfWrEn) begin
      if (qReg.size() == 0) check(0, "R1 R4 extra write", 64'(rfWrIdx), 64'd0);
      else begin
        check(int'(rfWrReg) == qReg[0], "R3 R7 R10 write register", 64'(rfWrReg), 64'(qReg[0]));
        check(int'(rfWrIdx) == qIdx[0], "R1 R10 write element index", 64'(rfWrIdx), 64'(qIdx[0]));
        check(int'(rfWrSize) == qSize[0], "R10 write size", 64'(rfWrSize), 64'(qSize[0]));
        check(rfWrData == qData[0], "R2 R4 R6 write data", rfWrData, qData[0]);
        void'(qReg.pop_front()); void'(qIdx.pop_front());
        void'(qSize.pop_front()); void'(qData.pop_front());
      end
    end
    if (done) begin
      doneSeen = 1;
      check(qReg.size() == 0 && qAddr.size() == 0, "R8 done with writes pending",
            64'(qReg.size()), 64'd0);
      check(!busy, "R8 busy low with done", 64'(busy), 64'd0);
    end
  end

  task automatic runLoad(input logic [AW-1:0] a, input int isz, input bit sgn,
                         input int esz, input int nm1, input int first,
                         input logic [VB-1:0] pred);
    for (int e = 0; e < (VB >> esz); e++) begin
      bit act = pred[e << esz];
      for (int k = 0; k <= nm1; k++) begin
        logic [AW-1:0] ia = a + AW'((e * (nm1 + 1) + k) << isz);
        if (act) qAddr.push_back(ia);
        qReg.push_back((first + k) % 32);
        qIdx.push_back(e);
        qSize.push_back(esz);
        qData.push_back(act ? refExt(readItem(ia, isz), isz, sgn, esz) : 64'd0);
      end
    end
    doneSeen = 0;
    curIsz   = isz;
    @(negedge clk);
    startPulse = 1'b1; startAddr = a; itemSize = 2'(isz); itemSigned = sgn;
    elemSize = 2'(esz); regCountM1 = 2'(nm1); firstReg = 5'(first); predBits = pred;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy, "R8 busy after start", 64'(busy), 64'd1);
    while (!doneSeen) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rfWrEn && !memReqValid, "R8 reset state",
          {60'd0, busy, done, rfWrEn, memReqValid}, 64'd0);
    // R1 R3: bytes, one register, all active
    runLoad(32'h100, 0, 0, 0, 0, 0, 16'hFFFF);
    // R4 R5: halves, two registers, alternating elements
    runLoad(32'h207, 1, 0, 1, 1, 5, 16'h3333);
    // R4: words, three registers, nothing active
    runLoad(32'h400, 2, 0, 2, 2, 10, 16'h0000);
    // R7: doublewords, four registers from 30
    runLoad(32'h800, 3, 0, 3, 3, 30, 16'h00FF);
    // R2: only non-lowest bytes set -> all inactive; then lowest bytes only
    runLoad(32'h900, 2, 0, 2, 0, 3, 16'hEEEE);
    runLoad(32'h940, 2, 0, 2, 0, 3, 16'h1111);
    // R3 R7: four byte registers from 29, alternating predicate, odd address
    runLoad(32'h3, 0, 0, 0, 3, 29, 16'h5555);
    // R6: every widening and signedness
    for (int i = 0; i < 3; i++)
      for (int j = i + 1; j < 4; j++)
        for (int s = 0; s < 2; s++)
          runLoad(32'hA00 + 32'(i * 64 + j * 16 + s * 8), i, s[0], j, 0, 7, 16'hFFFF);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule